// File: doc/BRIEF.md
# Wake-Up Controller Debug TAP

This block is a secondary JTAG test access port that sits beside an always-on wake-up controller. A debugger reaches it through the usual TCK/TMS/TDI/TDO pins and uses it to ask the power and reset logic for two actions: a reset of the whole MCU voltage domain, and a full chip erase. The port has a 4-bit instruction register. One instruction code selects an 8-bit request register and every other code selects a 1-bit bypass path. The TAP follows the standard 16-state controller.

A write to the request register takes effect in Update-DR. A reset request produces a one-cycle reset pulse. An erase request on its own is stored and can be read back, but it does nothing. The erase pulse fires only when the same written value also carries the domain reset bit. The erase itself is modelled as a fixed number of system-clock cycles, and a busy flag stays high for that time. The busy flag can also be read back through the data register.

The JTAG pins are oversampled on the system clock `clk` through synchronisers. TCK must therefore stay high and stay low for at least three `clk` cycles in each phase. The block has no streaming data path, so it has no valid/ready handshake. Every pin is a plain level or a single-cycle pulse.

Top module: `wuc_dbg_tap`

## Requirements
- R1: The instruction register is 4 bits wide. Capture-IR loads the pattern 4'b0001, and Shift-IR presents it on TDO least significant bit first, so the first bits out are 1, 0, 0, 0.
- R2: Instruction code 0x1 selects the 8-bit request register. Any other code selects a 1-bit bypass register. The bypass register captures 0 and delays TDI by one TCK, and an Update-DR through it produces no pulse.
- R3: Capture-DR on the request register loads the stored request bits 7..1 in place, with bit 0 replaced by the erase busy flag. The value shifts out least significant bit first, and TDI enters at bit 7.
- R4: At Update-DR with code 0x1 selected, the shifted value replaces the stored request. If bit 5 (domain reset) of the new value is set, `reset_pulse` is high for exactly one `clk` cycle.
- R5: `erase_pulse` is high for exactly one `clk` cycle at Update-DR only when bit 1 (erase) and bit 5 of the newly written value are both set and no erase is in progress. For example, 0x22 starts an erase.
- R6: A written value with bit 1 set and bit 5 clear is stored and reads back, but it produces no pulse. A later write erases only if that write itself has both bits set.
- R7: `erase_busy` rises in the same cycle as `erase_pulse` and stays high for exactly ERASE_CYCLES `clk` cycles.
- R8: A write with both bits set while `erase_busy` is high still gives the reset pulse. It starts no new erase and does not lengthen the busy window.
- R9: Entering Test-Logic-Reset clears the request register to 0 and sets the instruction register to 0xF (bypass). The state can be entered by TMS held high for five TCK or by `jtag_trst_n` low.
- R10: TDO changes only after a falling TCK edge. It is 0 after `clk` reset and whenever the controller is outside Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the JTAG pins and times the erase |
| rst_n | input | 1 | Active-low system reset |
| jtag_tck | input | 1 | Test clock, sampled as data |
| jtag_tms | input | 1 | Test mode select |
| jtag_tdi | input | 1 | Test data in |
| jtag_trst_n | input | 1 | Active-low test reset, forces Test-Logic-Reset |
| jtag_tdo | output | 1 | Test data out, updated after falling TCK |
| erase_pulse | output | 1 | One-cycle chip erase command to power/reset logic |
| reset_pulse | output | 1 | One-cycle MCU domain reset command |
| erase_busy | output | 1 | High while the timed erase runs |

## Verification
The bench builds the block with ERASE_CYCLES set to 200, and it drives TCK with six `clk` cycles per phase. At these values every one of the 16 instruction codes and all 256 request values can be swept, each one checked against readback and pulse counts worked out from the bit rules. The busy window is also short enough that a second erase write made right after the first still lands inside it. That makes the overlap case, and the busy bit seen during capture, reachable without long waits.

// File: rtl/wuc_tap_pkg.sv
package wuc_tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET   = 4'h0,
    ST_IDLE    = 4'h1,
    ST_SEL_DR  = 4'h2,
    ST_CAP_DR  = 4'h3,
    ST_SH_DR   = 4'h4,
    ST_EX1_DR  = 4'h5,
    ST_PAU_DR  = 4'h6,
    ST_EX2_DR  = 4'h7,
    ST_UPD_DR  = 4'h8,
    ST_SEL_IR  = 4'h9,
    ST_CAP_IR  = 4'hA,
    ST_SH_IR   = 4'hB,
    ST_EX1_IR  = 4'hC,
    ST_PAU_IR  = 4'hD,
    ST_EX2_IR  = 4'hE,
    ST_UPD_IR  = 4'hF
  } tap_state_e;

  function automatic tap_state_e tap_next(input tap_state_e cur, input logic tms);
    tap_state_e nxt;
    unique case (cur)
      ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/wuc_pin_sync.sv
module wuc_pin_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/wuc_tap_fsm.sv
module wuc_tap_fsm
  import wuc_tap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       tms,
  input  logic       force_reset,
  output tap_state_e state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           state <= ST_RESET;
    else if (force_reset) state <= ST_RESET;
    else if (step)        state <= tap_next(state, tms);
  end
endmodule

// File: rtl/wuc_erase_timer.sv
module wuc_erase_timer #(
  parameter int ERASE_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(ERASE_CYCLES + 1);
  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (start)          remain <= CW'(ERASE_CYCLES);
    else if (remain != '0)   remain <= remain - CW'(1);
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/wuc_dbg_tap.sv
module wuc_dbg_tap
  import wuc_tap_pkg::*;
#(
  parameter int IR_W         = 4,
  parameter int DR_W         = 8,
  parameter int REQ_IR_CODE  = 1,
  parameter int ERASE_BIT    = 1,
  parameter int RESET_BIT    = 5,
  parameter int ERASE_CYCLES = 4096,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic jtag_tck,
  input  logic jtag_tms,
  input  logic jtag_tdi,
  input  logic jtag_trst_n,
  output logic jtag_tdo,
  output logic erase_pulse,
  output logic reset_pulse,
  output logic erase_busy
);
  localparam int PIN_N = 4;
  localparam logic [PIN_N-1:0] PIN_RST = 4'b0010; // tms idles high, trst held

  // Pin order: [0] tck, [1] tms, [2] tdi, [3] trst_n
  logic [PIN_N-1:0] pins_s;
  logic             tck_d;
  logic             tck_rise, tck_fall;
  tap_state_e       state;

  wuc_pin_sync #(.W(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({jtag_trst_n, jtag_tdi, jtag_tms, jtag_tck}),
    .q     (pins_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tck_d <= 1'b0;
    else        tck_d <= pins_s[0];
  end

  assign tck_rise = pins_s[0] & ~tck_d;
  assign tck_fall = ~pins_s[0] & tck_d;

  wuc_tap_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .step        (tck_rise),
    .tms         (pins_s[1]),
    .force_reset (~pins_s[3]),
    .state       (state)
  );

  // Scan registers
  logic [IR_W-1:0] ir_sr, ir_q;
  logic [DR_W-1:0] dr_sr;
  logic [DR_W-1:1] req_q;
  logic            byp_q;
  logic            req_sel;
  logic            upd_req;
  logic            erase_start;

  assign req_sel     = (ir_q == IR_W'(REQ_IR_CODE));
  assign upd_req     = tck_rise && (state == ST_UPD_DR) && req_sel;
  assign erase_start = upd_req && dr_sr[ERASE_BIT] && dr_sr[RESET_BIT] && !erase_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_sr       <= '0;
      ir_q        <= '1;
      dr_sr       <= '0;
      req_q       <= '0;
      byp_q       <= 1'b0;
      erase_pulse <= 1'b0;
      reset_pulse <= 1'b0;
    end else begin
      erase_pulse <= 1'b0;
      reset_pulse <= 1'b0;
      if (state == ST_RESET) begin
        ir_q  <= '1;
        req_q <= '0;
      end else if (tck_rise) begin
        unique case (state)
          ST_CAP_IR: ir_sr <= IR_W'(1);
          ST_SH_IR:  ir_sr <= {pins_s[2], ir_sr[IR_W-1:1]};
          ST_UPD_IR: ir_q  <= ir_sr;
          ST_CAP_DR: begin
            byp_q <= 1'b0;
            dr_sr <= {req_q, erase_busy};
          end
          ST_SH_DR: begin
            byp_q <= pins_s[2];
            dr_sr <= {pins_s[2], dr_sr[DR_W-1:1]};
          end
          ST_UPD_DR: begin
            if (req_sel) begin
              req_q       <= dr_sr[DR_W-1:1];
              reset_pulse <= dr_sr[RESET_BIT];
              erase_pulse <= erase_start;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // TDO launched on the falling test clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) jtag_tdo <= 1'b0;
    else if (tck_fall) begin
      if (state == ST_SH_IR)      jtag_tdo <= ir_sr[0];
      else if (state == ST_SH_DR) jtag_tdo <= req_sel ? dr_sr[0] : byp_q;
      else                        jtag_tdo <= 1'b0;
    end
  end

  wuc_erase_timer #(.ERASE_CYCLES(ERASE_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (erase_start),
    .busy  (erase_busy)
  );

endmodule

// File: rtl/wuc_dbg_tap_chk.sv
module wuc_dbg_tap_chk #(
  parameter int ERASE_CYCLES = 4096
) (
  input logic clk,
  input logic rst_n,
  input logic erase_pulse,
  input logic reset_pulse,
  input logic erase_busy
);
  int busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           busy_len <= 0;
    else if (erase_pulse) busy_len <= 1;
    else if (erase_busy)  busy_len <= busy_len + 1;
  end

  a_r4_reset_single: assert property (@(posedge clk) disable iff (!rst_n)
    reset_pulse |=> !reset_pulse);

  a_r5_erase_single: assert property (@(posedge clk) disable iff (!rst_n)
    erase_pulse |=> !erase_pulse);

  a_r5_erase_paired: assert property (@(posedge clk) disable iff (!rst_n)
    erase_pulse |-> reset_pulse);

  a_r7_busy_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_busy) |-> erase_pulse);

  a_r7_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(erase_busy) |-> (busy_len == ERASE_CYCLES));

  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    erase_pulse |-> !$past(erase_busy));
endmodule

bind wuc_dbg_tap wuc_dbg_tap_chk #(.ERASE_CYCLES(ERASE_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .erase_pulse (erase_pulse),
  .reset_pulse (reset_pulse),
  .erase_busy  (erase_busy)
);

// File: tb/wuc_dbg_tap_tb.sv
`timescale 1ns/1ps
module wuc_dbg_tap_tb;
  localparam int ERASE_N = 200;
  localparam int HALF    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tck = 1'b0, tms = 1'b1, tdi = 1'b0, trst_n = 1'b1;
  logic tdo, erase_pulse, reset_pulse, erase_busy;

  int total = 0, bad = 0;
  int e_cnt = 0, r_cnt = 0;
  int run_len = 0, last_len = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wuc_dbg_tap #(.ERASE_CYCLES(ERASE_N)) u_dut (
    .clk(clk), .rst_n(rst_n), .jtag_tck(tck), .jtag_tms(tms), .jtag_tdi(tdi),
    .jtag_trst_n(trst_n), .jtag_tdo(tdo), .erase_pulse(erase_pulse),
    .reset_pulse(reset_pulse), .erase_busy(erase_busy)
  );

  always @(posedge clk) begin
    if (erase_pulse) e_cnt++;
    if (reset_pulse) r_cnt++;
    if (erase_busy) run_len++;
    else if (run_len != 0) begin
      last_len = run_len;
      run_len = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tck_cycle(input logic m, input logic d, output logic o);
    @(negedge clk);
    tms = m; tdi = d; tck = 1'b0;
    repeat (HALF) @(negedge clk);
    o = tdo;
    tck = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic tap_reset();
    logic o;
    for (int i = 0; i < 5; i++) tck_cycle(1'b1, 1'b0, o);
    tck_cycle(1'b0, 1'b0, o);
  endtask

  task automatic scan_ir(input logic [3:0] code, output logic [3:0] cap);
    logic o;
    tck_cycle(1'b1, 1'b0, o);
    tck_cycle(1'b1, 1'b0, o);
    tck_cycle(1'b0, 1'b0, o);
    tck_cycle(1'b0, 1'b0, o);
    for (int i = 0; i < 4; i++) tck_cycle(i == 3, code[i], cap[i]);
    tck_cycle(1'b1, 1'b0, o);
    tck_cycle(1'b0, 1'b0, o);
  endtask

  task automatic scan_dr(input logic [7:0] val, output logic [7:0] cap);
    logic o;
    tck_cycle(1'b1, 1'b0, o);
    tck_cycle(1'b0, 1'b0, o);
    tck_cycle(1'b0, 1'b0, o);
    for (int i = 0; i < 8; i++) tck_cycle(i == 7, val[i], cap[i]);
    tck_cycle(1'b1, 1'b0, o);
    tck_cycle(1'b0, 1'b0, o);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] icap;
    logic [7:0] o;
    logic [7:0] prev;
    int e0, r0;

    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    // R10 reset state
    check(tdo == 1'b0, "R10 reset tdo", tdo, 0);
    check(erase_busy == 1'b0, "R7 reset busy", erase_busy, 0);
    check(e_cnt == 0 && r_cnt == 0, "R4 reset pulses", e_cnt + r_cnt, 0);

    tap_reset();
    // R9 instruction resets to bypass
    scan_dr(8'hA5, o);
    check(o == 8'h4A, "R9 default bypass", o, 8'h4A);

    // R1/R2 sweep all instruction codes
    for (int c = 0; c < 16; c++) begin
      scan_ir(4'(c), icap);
      check(icap == 4'b0001, "R1 capture-IR", icap, 1);
      e0 = e_cnt; r0 = r_cnt;
      if (c != 1) begin
        scan_dr(8'hA5, o);
        check(o == 8'h4A, "R2 bypass delay", o, 8'h4A);
        check(e_cnt == e0 && r_cnt == r0, "R2 bypass no pulse", r_cnt - r0, 0);
      end else begin
        scan_dr(8'h00, o);
        check(o == 8'h00, "R3 empty readback", o, 0);
      end
    end
    scan_ir(4'h1, icap);
    // R10 idle output
    check(tdo == 1'b0, "R10 idle tdo", tdo, 0);

    // R3..R6 sweep all request values
    prev = 8'h00;
    for (int v = 0; v < 256; v++) begin
      e0 = e_cnt; r0 = r_cnt;
      scan_dr(8'(v), o);
      check(o == {prev[7:1], 1'b0}, "R3 readback", o, {prev[7:1], 1'b0});
      check(r_cnt - r0 == int'(v[5]), "R4 reset pulse", r_cnt - r0, int'(v[5]));
      check(e_cnt - e0 == int'(v[5] & v[1]), "R5 R6 erase pairing", e_cnt - e0, int'(v[5] & v[1]));
      if (v[5] && v[1]) begin
        repeat (ERASE_N + 20) @(negedge clk);
        check(last_len == ERASE_N, "R7 busy length", last_len, ERASE_N);
      end
      prev = 8'(v);
    end

    // R6 latent erase then reset-only write
    e0 = e_cnt; r0 = r_cnt;
    scan_dr(8'h02, o);
    scan_dr(8'h20, o);
    check(o == 8'h02, "R6 latent stored", o, 8'h02);
    check(e_cnt == e0, "R6 no erase", e_cnt - e0, 0);
    check(r_cnt - r0 == 1, "R6 reset only", r_cnt - r0, 1);

    // R8 overlap and R3 busy readback
    e0 = e_cnt; r0 = r_cnt;
    scan_dr(8'h22, o);
    scan_dr(8'h22, o);
    check(o == 8'h23, "R3 busy bit", o, 8'h23);
    repeat (ERASE_N + 20) @(negedge clk);
    check(e_cnt - e0 == 1, "R8 single erase", e_cnt - e0, 1);
    check(r_cnt - r0 == 2, "R8 reset kept", r_cnt - r0, 2);
    check(last_len == ERASE_N, "R8 window not extended", last_len, ERASE_N);
    scan_dr(8'h00, o);
    check(o == 8'h22, "R3 busy clear", o, 8'h22);

    // R9 TMS reset clears request
    scan_dr(8'h02, o);
    tap_reset();
    scan_ir(4'h1, icap);
    scan_dr(8'h00, o);
    check(o == 8'h00, "R9 tms reset clears", o, 0);

    // R9 trst clears request and instruction
    scan_dr(8'h42, o);
    @(negedge clk); trst_n = 1'b0;
    repeat (10) @(negedge clk); trst_n = 1'b1;
    repeat (4) @(negedge clk);
    tck_cycle(1'b0, 1'b0, o[0]);
    scan_dr(8'hA5, o);
    check(o == 8'h4A, "R9 trst bypass", o, 8'h4A);
    scan_ir(4'h1, icap);
    scan_dr(8'h00, o);
    check(o == 8'h00, "R9 trst clears", o, 0);
    check(tdo == 1'b0, "R10 idle after scan", tdo, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule